// File: doc/BRIEF.md
# Quarter-Phase Multiplexer Select and Conversion-Start Timer

This block derives two time bases from one clock and releases them on the same edge. The slow base spans one full scan of a four-input analog multiplexer and drives a 2-bit select code that moves to a new value at each quarter of its period. The code is formed by two square waves of 50% duty, the second trailing the first by a quarter period, so exactly one select bit toggles at each step and the codes follow a Gray order.

The fast base runs at exactly four times the slow rate. It issues a one-clock conversion-start pulse a programmable number of clocks after every select change, so a converter samples while the select code is settled. A 2-bit slot index tells which of the four quarters the pulse belongs to. The periods and the delay are held on input pins while the block is idle and are captured on the start strobe; after that only a reset stops the time bases.

Top module: `quad_phase_timer`

## Requirements
- R1: After reset and until the first start strobe, `sel_o`, `conv_o` and `slot_o` are all 0.
- R2: A high `go_i` at a rising clock edge while idle releases both time bases on that edge; the cycle after that edge is count 0 of both, showing `sel_o` = 2'b10 and `slot_o` = 0. A `go_i` pulse while running has no effect on any output.
- R3: The slow period is `slow_mod_i`+1 clocks and the fast period `fast_mod_i`+1 clocks, both captured on the start edge; later changes of `slow_mod_i`, `fast_mod_i` or `delay_i` have no effect. The caller keeps `slow_mod_i`+1 = 4 × (`fast_mod_i`+1), `fast_mod_i` ≥ 1 and `delay_i` ≤ `fast_mod_i`.
- R4: With Q = (`slow_mod_i`+1)/4 and n the slow count, `sel_o` is 2'b10 for n in [0,Q), 2'b11 for [Q,2Q), 2'b01 for [2Q,3Q) and 2'b00 for [3Q,4Q).
- R5: `sel_o[1]` is high for the first half of each slow period and `sel_o[0]` for its middle half, so no two select bits change in the same cycle.
- R6: `conv_o` is high for exactly one clock when the fast count equals `delay_i`, i.e. `delay_i` clocks after each select change; with `delay_i` = 0 it rises in the same cycle as the select change.
- R7: `slot_o` counts 0,1,2,3 and advances when the fast base wraps, so it equals the quarter index of R4 (0 for 2'b10, 1 for 2'b11, 2 for 2'b01, 3 for 2'b00).
- R8: Asserting `rst_ni` low at any time forces all outputs to 0 at once and returns the block to idle; a new start strobe is then needed.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both time bases |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go_i | input | 1 | Start strobe, acts only while idle |
| slow_mod_i | input | CNT_W | Slow terminal count (period minus one) |
| fast_mod_i | input | CNT_W | Fast terminal count (period minus one) |
| delay_i | input | CNT_W | Clocks from select change to conversion start |
| sel_o | output | 2 | Multiplexer select code |
| conv_o | output | 1 | One-clock conversion-start pulse |
| slot_o | output | 2 | Quarter index of the current select code |

## Verification
Two functions can land in the same cycle: the select change from the slow base and the conversion pulse from the fast base, which coincide when the delay is 0, while the slot advance from the fast wrap coincides with every select change. The bench provokes this with a zero-delay run and contrasts it with a maximum-delay run where the pulse sits in the last clock of a quarter. Each cycle's select, pulse and slot are compared against values computed from the cycle count since the start edge, so a pulse one clock early or a slot stepping out of line with the select code shows up as a miscompare.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

  localparam int unsigned SLOTS  = 4;
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned SEL_W  = 2;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  typedef logic [SLOT_W-1:0] slot_t;

  // select code shown during each quarter of the slow period
  function automatic logic [SEL_W-1:0] slot_code(input slot_t s);
    logic [SEL_W-1:0] c;
    case (s)
      2'd0:    c = 2'b10;
      2'd1:    c = 2'b11;
      2'd2:    c = 2'b01;
      default: c = 2'b00;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/qpt_wrap_counter.sv
module qpt_wrap_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_nxt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else if (cnt_q == mod_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_nxt_o = en_i ? cnt_d : cnt_q;

endmodule

// File: rtl/qpt_cmp_edge.sv
module qpt_cmp_edge #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_nxt_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic [W-1:0] rise_at_i,
  input  logic [W-1:0] fall_at_i,
  output logic         q_o
);

  logic q_d;

  // one compare sets the output, the other clears it
  always_comb begin
    if (!run_nxt_i) begin
      q_d = 1'b0;
    end else if (cnt_nxt_i == rise_at_i) begin
      q_d = 1'b1;
    end else if (cnt_nxt_i == fall_at_i) begin
      q_d = 1'b0;
    end else begin
      q_d = q_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      q_o <= q_d;
    end
  end

endmodule

// File: rtl/qpt_conv_gen.sv
module qpt_conv_gen
  import qpt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_q_i,
  input  logic         run_nxt_i,
  input  logic [W-1:0] fcnt_nxt_i,
  input  logic [W-1:0] delay_i,
  output logic         conv_o,
  output slot_t        slot_o
);

  logic  conv_d;
  slot_t slot_d;
  logic  fwrap;

  // next fast count returns to zero only on a wrap once running
  assign fwrap = run_q_i && (fcnt_nxt_i == '0);

  always_comb begin
    conv_d = run_nxt_i && (fcnt_nxt_i == delay_i);
    if (!run_nxt_i) begin
      slot_d = '0;
    end else if (fwrap) begin
      slot_d = slot_o + 1'b1;
    end else begin
      slot_d = slot_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_o <= 1'b0;
      slot_o <= '0;
    end else begin
      conv_o <= conv_d;
      slot_o <= slot_d;
    end
  end

endmodule

// File: rtl/quad_phase_timer.sv
module quad_phase_timer
  import qpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] slow_mod_i,
  input  logic [CNT_W-1:0] fast_mod_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic [1:0]       sel_o,
  output logic             conv_o,
  output logic [1:0]       slot_o
);

  localparam int unsigned PLEN_W = CNT_W + 1;
  localparam int unsigned NBITS  = SEL_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  // run state
  phase_e run_q, run_d;
  logic   fire;
  logic   run_now, run_nxt;

  assign fire    = (run_q == PH_IDLE) && go_i;
  assign run_now = (run_q == PH_RUN);

  always_comb begin
    run_d = run_q;
    if (fire) begin
      run_d = PH_RUN;
    end
  end
  assign run_nxt = (run_d == PH_RUN);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= PH_IDLE;
    end else begin
      run_q <= run_d;
    end
  end

  // configuration captured on the start edge
  logic [CNT_W-1:0] smod_q, fmod_q, dly_q, qlen_q;
  logic [CNT_W-1:0] qlen_in, qlen_eff, dly_eff;

  assign qlen_in  = CNT_W'(({1'b0, slow_mod_i} + PLEN_W'(1)) >> 2);
  assign qlen_eff = fire ? qlen_in : qlen_q;
  assign dly_eff  = fire ? delay_i : dly_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      smod_q <= '0;
      fmod_q <= '0;
      dly_q  <= '0;
      qlen_q <= '0;
    end else if (fire) begin
      smod_q <= slow_mod_i;
      fmod_q <= fast_mod_i;
      dly_q  <= delay_i;
      qlen_q <= qlen_in;
    end
  end

  // the two time bases
  logic [CNT_W-1:0] scnt_nxt, fcnt_nxt;

  qpt_wrap_counter #(.W(CNT_W)) u_slow_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .en_i      (run_nxt),
    .clr_i     (!run_now),
    .mod_i     (smod_q),
    .cnt_nxt_o (scnt_nxt)
  );

  qpt_wrap_counter #(.W(CNT_W)) u_fast_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .en_i      (run_nxt),
    .clr_i     (!run_now),
    .mod_i     (fmod_q),
    .cnt_nxt_o (fcnt_nxt)
  );

  // select bits: bit 1 spans quarters 0-1, bit 0 spans quarters 1-2
  logic [NBITS-1:0] sel_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    logic [CNT_W-1:0] rise_at, fall_at;
    assign rise_at = qlen_eff * CNT_W'(i);
    assign fall_at = qlen_eff * CNT_W'(i + 2);

    qpt_cmp_edge #(.W(CNT_W)) u_edge (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .run_nxt_i (run_nxt),
      .cnt_nxt_i (scnt_nxt),
      .rise_at_i (rise_at),
      .fall_at_i (fall_at),
      .q_o       (sel_q[NBITS-1-i])
    );
  end

  slot_t slot_q;

  qpt_conv_gen #(.W(CNT_W)) u_conv (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_q_i    (run_now),
    .run_nxt_i  (run_nxt),
    .fcnt_nxt_i (fcnt_nxt),
    .delay_i    (dly_eff),
    .conv_o     (conv_o),
    .slot_o     (slot_q)
  );

  assign sel_o  = sel_q;
  assign slot_o = slot_q;

endmodule

// File: rtl/qpt_checker.sv
module qpt_checker
  import qpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             run,
  input logic [1:0]       sel,
  input logic             conv,
  input logic [1:0]       slot,
  input logic [CNT_W-1:0] qlen,
  input logic [CNT_W-1:0] dly,
  input logic [CNT_W-1:0] smod,
  input logic [CNT_W-1:0] fmod
);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run |-> (sel == 2'b00) && !conv && (slot == 2'b00));

  p_start_code_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(run) |-> (sel == 2'b10) && (slot == 2'b00));

  p_cfg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(qlen) && $stable(dly) && $stable(smod) && $stable(fmod)));

  p_sel_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    run |-> (sel == slot_code(slot)));

  p_gray_step_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run && $past(run)) |-> ($countones(sel ^ $past(sel)) <= 1));

  p_conv_single_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    conv |=> !conv);

  p_slot_step_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run && $past(run) && (slot != $past(slot))) |-> (slot == $past(slot) + 2'd1));

endmodule

bind quad_phase_timer qpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i (clk_i),
  .rst_n (rst_n),
  .run   (run_now),
  .sel   (sel_o),
  .conv  (conv_o),
  .slot  (slot_o),
  .qlen  (qlen_q),
  .dly   (dly_q),
  .smod  (smod_q),
  .fmod  (fmod_q)
);

// File: tb/quad_phase_timer_tb.sv
module quad_phase_timer_tb;

  localparam int unsigned W = 16;

  logic         clk;
  logic         rst_ni;
  logic         go_i;
  logic [W-1:0] slow_mod_i, fast_mod_i, delay_i;
  logic [1:0]   sel_o;
  logic         conv_o;
  logic [1:0]   slot_o;

  quad_phase_timer #(.CNT_W(W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .go_i       (go_i),
    .slow_mod_i (slow_mod_i),
    .fast_mod_i (fast_mod_i),
    .delay_i    (delay_i),
    .sel_o      (sel_o),
    .conv_o     (conv_o),
    .slot_o     (slot_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [1:0] sel;
    logic       conv;
    logic [1:0] slot;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   cyc   = 0;

  // expected outputs k cycles after the start edge
  task automatic push_run(input int sm, input int fm, input int dly,
                          input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      int per  = sm + 1;
      int q    = per / 4;
      int quar = (k % per) / q;
      case (quar)
        0:       e.sel = 2'b10;
        1:       e.sel = 2'b11;
        2:       e.sel = 2'b01;
        default: e.sel = 2'b00;
      endcase
      e.conv = ((k % (fm + 1)) == dly);
      e.slot = 2'((k / (fm + 1)) % 4);
      e.tag  = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic push_idle(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.sel  = 2'b00;
      e.conv = 1'b0;
      e.slot = 2'b00;
      e.tag  = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(posedge clk);
    #1;
  endtask

  // drive a start strobe; expectations are queued before the next sample
  task automatic start_run(input int sm, input int fm, input int dly,
                           input int n, input string tag);
    slow_mod_i = W'(sm);
    fast_mod_i = W'(fm);
    delay_i    = W'(dly);
    go_i       = 1'b1;
    @(posedge clk);
    #1;
    go_i = 1'b0;
    push_run(sm, fm, dly, n, tag);
    // R3: settings moved after the start edge must be ignored
    slow_mod_i = 16'd99;
    fast_mod_i = 16'd5;
    delay_i    = 16'd4;
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic bad;
      e   = sb_q.pop_front();
      bad = 1'b0;
      n_vec++;
      if (sel_o !== e.sel) begin
        $display("FAIL R4 R5 [%s] sel got %b expected %b", e.tag, sel_o, e.sel);
        bad = 1'b1;
      end
      if (conv_o !== e.conv) begin
        $display("FAIL R6 [%s] conv got %b expected %b", e.tag, conv_o, e.conv);
        bad = 1'b1;
      end
      if (slot_o !== e.slot) begin
        $display("FAIL R7 [%s] slot got %0d expected %0d", e.tag, slot_o, e.slot);
        bad = 1'b1;
      end
      if (bad) n_bad++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired, got %0d cycles expected fewer", cyc);
      n_bad++;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni     = 1'b1;
    go_i       = 1'b0;
    slow_mod_i = 16'd15;
    fast_mod_i = 16'd3;
    delay_i    = 16'd1;
    #1 rst_ni  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    push_idle(3, "R1 in reset");
    drain();
    rst_ni = 1'b1;
    push_idle(6, "R1 idle after reset");
    drain();

    // R2 R3: small periods, then a start strobe mid-run that must be ignored
    start_run(15, 3, 1, 48, "R2 R3 period 16");
    repeat (20) @(posedge clk);
    #1 go_i = 1'b1;
    @(posedge clk);
    #1 go_i = 1'b0;
    drain();

    // R8: reset in the middle of a run
    rst_ni = 1'b0;
    push_idle(3, "R8 reset mid-run");
    drain();
    rst_ni = 1'b1;
    push_idle(6, "R8 idle until new start");
    drain();

    // R6: zero delay, pulse coincides with the select change
    start_run(39, 9, 0, 90, "R6 zero delay");
    drain();

    rst_ni = 1'b0;
    push_idle(2, "R8 reset");
    drain();
    rst_ni = 1'b1;
    push_idle(4, "R1 idle");
    drain();

    // R6: largest delay, pulse in the last clock of each quarter
    start_run(31, 7, 7, 70, "R6 max delay");
    drain();

    rst_ni = 1'b0;
    push_idle(2, "R8 reset");
    drain();
    rst_ni = 1'b1;
    push_idle(4, "R1 idle");
    drain();

    // R3: full-size periods across two slow wraps
    start_run(11999, 2999, 100, 24100, "R3 full size");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule